// File: doc/BRIEF.md
# Bus Arbiter Interrupt Status Unit

This unit gathers the interrupt events of a four-master bus arbiter and presents them in one 32-bit status word. For each master it watches the grant line and the master's transaction-start response. If a granted master has not begun a transaction within 16 clocks of receiving the grant, the unit marks that master as broken. The unit also captures one-clock system-error pulses on an active-low error line, and a clock-running event that arrives as a pulse.

Software reads both the status word and a companion mask word through a small register port. Writing 1 to a status bit toggles that bit. A bit that is set is cleared, which removes its interrupt. A bit that is clear is set, which lets software raise an interrupt for diagnostics. A single registered interrupt output is asserted when any status bit and its mask bit are both 1. The arbitration logic, the bus engine and the clock-detection logic lie outside this unit and drive its inputs.

Top module: `arb_irq_status`

## Requirements
- R1: After a synchronous reset, the status word, the mask word, the read data and the interrupt output are all 0.
- R2: Master i has its own status bit at position i (0 to 3). That bit is set when the master's grant is high for 16 consecutive clocks and start stays low throughout; the clock on which the grant rises counts as the first. If start is high on any of those 16 clocks, including the 16th, the bit is not set.
- R3: If the grant falls before the 16th clock, the bit is not set. Each grant period sets the bit at most once, so a bit that is cleared while the same grant is still held stays clear.
- R4: A low level on the active-low error input for a single clock sets status bit 4.
- R5: A one-clock pulse on the clock-running event input sets status bit 5.
- R6: Writing to word address 0 with a 1 in a position whose status bit is 1 clears that bit.
- R7: Writing to word address 0 with a 1 in a position whose status bit is 0 sets that bit. A 0 in the written data leaves the bit unchanged.
- R8: Bits 31 to 6 of both words always read as 0, even after 1s are written to them. Word addresses 2 and 3 read as 0.
- R9: The mask word is written and read at word address 1, and its 6 low bits read back exactly as they were written.
- R10: The interrupt output goes high one clock after some status bit and its mask bit are both 1. It stays low while the mask is 0, and it falls once every masked bit has been cleared.
- R11: If a hardware event sets a bit on the same clock that a software write of 1 reaches that bit, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grant_i | input | 4 | Per-master bus grant from the arbiter |
| start_i | input | 4 | Per-master transaction-start response |
| serr_n_i | input | 1 | System error line, active low |
| clkrun_evt_i | input | 1 | Clock-running event pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 status, 1 mask |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for reg_addr_i |
| irq_o | output | 1 | Combined masked interrupt, registered |

## Verification
The broken-master timer is tested with three grant patterns. A grant held with no response is expected to set the flag. A response that arrives on exactly the 16th clock is expected to block it, and a grant that falls after the 15th clock is also expected to block it; together these two cases pin the timeout down to one exact cycle. A long grant whose flag is cleared partway through distinguishes a flag raised once per grant from one that re-arms while the grant is still held. The write-1 toggle is driven against both a set bit and a clear bit, with 0s in the other positions. A clock-running pulse is made to reach the status bit on the same clock as a clearing write, which shows whether the hardware set takes priority.

// File: rtl/arb_irq_pkg.sv
package arb_irq_pkg;
  localparam int unsigned STATUS_IDX = 0;
  localparam int unsigned ENABLE_IDX = 1;

  typedef enum logic [1:0] {
    SEL_STATUS,
    SEL_ENABLE,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/arb_bkm_watch.sv
module arb_bkm_watch #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic grant_i,
  input  logic start_i,
  output logic fire_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic             grant_q;
  logic             waiting_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q   <= 1'b0;
      waiting_q <= 1'b0;
      cnt_q     <= '0;
      fire_o    <= 1'b0;
    end else begin
      grant_q <= grant_i;
      fire_o  <= 1'b0;
      if (!grant_i || start_i) begin
        waiting_q <= 1'b0;
        cnt_q     <= '0;
      end else if (!grant_q) begin
        // first granted clock counts as clock 1
        waiting_q <= 1'b1;
        cnt_q     <= CNT_W'(1);
      end else if (waiting_q) begin
        if (cnt_q == LAST) begin
          fire_o    <= 1'b1;
          waiting_q <= 1'b0;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arb_evt_capture.sv
module arb_evt_capture #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) pulse_o <= '0;
    else     pulse_o <= evt_i;
  end
endmodule

// File: rtl/arb_irq_regs.sv
module arb_irq_regs
  import arb_irq_pkg::*;
#(
  parameter int unsigned STAT_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] hw_set_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - STAT_W;

  reg_sel_e          sel;
  logic [STAT_W-1:0] toggle;
  logic [STAT_W-1:0] status_d;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:STAT_W];

  always_comb begin
    if (addr_i == ADDR_W'(STATUS_IDX))      sel = SEL_STATUS;
    else if (addr_i == ADDR_W'(ENABLE_IDX)) sel = SEL_ENABLE;
    else                                    sel = SEL_NONE;
  end

  assign toggle   = (wr_i && sel == SEL_STATUS) ? wdata_i[STAT_W-1:0] : '0;
  // hardware set is ORed after the toggle so it takes priority
  assign status_d = (status_o ^ toggle) | hw_set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      enable_o <= '0;
      rdata_o  <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= status_d;
      if (wr_i && sel == SEL_ENABLE) enable_o <= wdata_i[STAT_W-1:0];
      irq_o <= |(status_o & enable_o);
      case (sel)
        SEL_STATUS: rdata_o <= {{PAD_W{1'b0}}, status_o};
        SEL_ENABLE: rdata_o <= {{PAD_W{1'b0}}, enable_o};
        default:    rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/arb_irq_status.sv
module arb_irq_status #(
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned TIMEOUT     = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] grant_i,
  input  logic [NUM_MASTERS-1:0] start_i,
  input  logic                   serr_n_i,
  input  logic                   clkrun_evt_i,
  input  logic                   reg_wr_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  output logic                   irq_o
);
  localparam int unsigned STAT_W = NUM_MASTERS + 2;

  logic [NUM_MASTERS-1:0] bkm_fire;
  logic [1:0]             evt_q;
  logic [STAT_W-1:0]      hw_set_w;
  logic [STAT_W-1:0]      status_w;
  logic [STAT_W-1:0]      enable_w;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_watch
    arb_bkm_watch #(.TIMEOUT(TIMEOUT)) i_watch (
      .clk    (clk),
      .rst    (rst),
      .grant_i(grant_i[m]),
      .start_i(start_i[m]),
      .fire_o (bkm_fire[m])
    );
  end

  arb_evt_capture #(.W(2)) i_evt (
    .clk    (clk),
    .rst    (rst),
    .evt_i  ({clkrun_evt_i, ~serr_n_i}),
    .pulse_o(evt_q)
  );

  assign hw_set_w = {evt_q, bkm_fire};

  arb_irq_regs #(
    .STAT_W(STAT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_regs (
    .clk     (clk),
    .rst     (rst),
    .hw_set_i(hw_set_w),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .status_o(status_w),
    .enable_o(enable_w),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/arb_irq_status_chk.sv
module arb_irq_status_chk #(
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   serr_n_i,
  input logic                   clkrun_evt_i,
  input logic                   reg_wr_i,
  input logic [ADDR_W-1:0]      reg_addr_i,
  input logic [DATA_W-1:0]      reg_wdata_i,
  input logic [DATA_W-1:0]      reg_rdata_o,
  input logic                   irq_o,
  input logic [NUM_MASTERS+1:0] status_w,
  input logic [NUM_MASTERS+1:0] enable_w,
  input logic [NUM_MASTERS+1:0] hw_set_w
);
  localparam int unsigned STAT_W = NUM_MASTERS + 2;

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata_o[DATA_W-1:STAT_W] == '0);

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_w == '0) |=> !irq_o);

  // R4
  serr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !serr_n_i |=> ##1 status_w[NUM_MASTERS]);

  // R5
  clkrun_capture_chk: assert property (@(posedge clk) disable iff (rst)
    clkrun_evt_i |=> ##1 status_w[NUM_MASTERS+1]);

  // R3
  bkm_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_set_w[NUM_MASTERS-1:0] != '0) |=>
      ((hw_set_w[NUM_MASTERS-1:0] & $past(hw_set_w[NUM_MASTERS-1:0])) == '0));

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    // R6
    w1_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr_i && reg_addr_i == '0 && reg_wdata_i[b] && status_w[b] && !hw_set_w[b])
        |=> !status_w[b]);
    // R11
    hw_priority_chk: assert property (@(posedge clk) disable iff (rst)
      hw_set_w[b] |=> status_w[b]);
  end
endmodule

bind arb_irq_status arb_irq_status_chk #(
  .NUM_MASTERS(NUM_MASTERS),
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .serr_n_i    (serr_n_i),
  .clkrun_evt_i(clkrun_evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .status_w    (status_w),
  .enable_w    (enable_w),
  .hw_set_w    (hw_set_w)
);

// File: tb/test_arb_irq_status.sv
module test_arb_irq_status;
  localparam int NM = 4;
  localparam int LIMIT = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NM-1:0] grant = '0;
  logic [NM-1:0] start = '0;
  logic          serr_n = 1'b1;
  logic          clkrun = 1'b0;
  logic          wr = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  arb_irq_status i_arb_irq_status (
    .clk         (clk),
    .rst         (rst),
    .grant_i     (grant),
    .start_i     (start),
    .serr_n_i    (serr_n),
    .clkrun_evt_i(clkrun),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    cycles(2);
    d = rdata;
  endtask

  task automatic clear_all();
    logic [31:0] s;
    reg_read(2'd0, s);
    if (s != 0) reg_write(2'd0, s);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq at reset", {31'b0, irq}, 32'h0);
    chk("R1 rdata at reset", rdata, 32'h0);
    rst = 1'b0;
    reg_read(2'd0, d); chk("R1 status after reset", d, 32'h0);
    reg_read(2'd1, d); chk("R1 mask after reset", d, 32'h0);
  endtask

  task automatic t_bkm_timeout();
    logic [31:0] d;
    for (int m = 0; m < NM; m++) begin
      @(negedge clk); grant[m] = 1'b1;
      cycles(LIMIT + 4);
      grant[m] = 1'b0;
      reg_read(2'd0, d);
      chk($sformatf("R2 master %0d timeout flag", m), d, 32'h1 << m);
      clear_all();
    end
  endtask

  task automatic t_bkm_boundary();
    logic [31:0] d;
    // response on exactly the 16th granted clock
    @(negedge clk); grant[1] = 1'b1;
    repeat (LIMIT - 1) @(posedge clk);
    @(negedge clk); start[1] = 1'b1;
    @(posedge clk);
    @(negedge clk); start[1] = 1'b0; grant[1] = 1'b0;
    cycles(4);
    reg_read(2'd0, d); chk("R2 start on clock 16 blocks flag", d, 32'h0);
    // grant removed after 15 clocks
    @(negedge clk); grant[3] = 1'b1;
    repeat (LIMIT - 1) @(posedge clk);
    @(negedge clk); grant[3] = 1'b0;
    cycles(6);
    reg_read(2'd0, d); chk("R3 grant drop at clock 15 blocks flag", d, 32'h0);
  endtask

  task automatic t_bkm_once();
    logic [31:0] d;
    @(negedge clk); grant[2] = 1'b1;
    cycles(LIMIT + 4);
    reg_write(2'd0, 32'h4);
    cycles(LIMIT + 10);
    reg_read(2'd0, d); chk("R3 no re-flag while grant held", d, 32'h0);
    grant[2] = 1'b0;
  endtask

  task automatic t_serr();
    logic [31:0] d;
    @(negedge clk); serr_n = 1'b0;
    @(negedge clk); serr_n = 1'b1;
    cycles(2);
    reg_read(2'd0, d); chk("R4 error pulse sets bit 4", d, 32'h10);
    clear_all();
  endtask

  task automatic t_clkrun();
    logic [31:0] d;
    @(negedge clk); clkrun = 1'b1;
    @(negedge clk); clkrun = 1'b0;
    cycles(2);
    reg_read(2'd0, d); chk("R5 clock-running pulse sets bit 5", d, 32'h20);
    clear_all();
    reg_read(2'd0, d); chk("R6 write 1 clears set bit 5", d, 32'h0);
  endtask

  task automatic t_toggle();
    logic [31:0] d;
    reg_write(2'd0, 32'h0000_0009);
    reg_read(2'd0, d); chk("R7 write 1 sets clear bits", d, 32'h9);
    reg_write(2'd0, 32'h0000_0000);
    reg_read(2'd0, d); chk("R7 write 0 has no effect", d, 32'h9);
    reg_write(2'd0, 32'h0000_0001);
    reg_read(2'd0, d); chk("R6 write 1 clears only bit 0", d, 32'h8);
    clear_all();
  endtask

  task automatic t_reserved_mask();
    logic [31:0] d;
    reg_write(2'd1, 32'hFFFF_FFEA);
    reg_read(2'd1, d); chk("R9 mask readback", d, 32'h2A);
    chk("R8 mask upper bits zero", d & 32'hFFFF_FFC0, 32'h0);
    reg_write(2'd0, 32'hFFFF_FFC0);
    reg_read(2'd0, d); chk("R8 status upper bits zero", d, 32'h0);
    reg_read(2'd2, d); chk("R8 unused address reads 0", d, 32'h0);
    reg_write(2'd1, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    reg_write(2'd0, 32'h2);
    cycles(3);
    chk("R10 no irq with mask 0", {31'b0, irq}, 32'h0);
    reg_write(2'd1, 32'h1);
    cycles(3);
    chk("R10 no irq with unmatched mask", {31'b0, irq}, 32'h0);
    @(negedge clk); wr = 1'b1; addr = 2'd1; wdata = 32'h2;
    @(posedge clk);
    @(negedge clk); wr = 1'b0;
    chk("R10 irq not yet one clock before", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq one clock after match", {31'b0, irq}, 32'h1);
    reg_write(2'd0, 32'h2);
    cycles(1);
    chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
    reg_read(2'd0, d);
    reg_write(2'd1, 32'h0);
  endtask

  task automatic t_hw_wins();
    logic [31:0] d;
    @(negedge clk); clkrun = 1'b1;
    @(negedge clk); clkrun = 1'b0;
    cycles(2);
    @(negedge clk); clkrun = 1'b1;
    @(posedge clk);
    @(negedge clk); clkrun = 1'b0; wr = 1'b1; addr = 2'd0; wdata = 32'h20;
    @(posedge clk);
    @(negedge clk); wr = 1'b0; wdata = '0;
    reg_read(2'd0, d); chk("R11 hardware set beats write 1", d, 32'h20);
    clear_all();
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cycles(4);
    t_reset();
    t_bkm_timeout();
    t_bkm_boundary();
    t_bkm_once();
    t_serr();
    t_clkrun();
    t_toggle();
    t_reserved_mask();
    t_irq();
    t_hw_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule